// File: doc/BRIEF.md
# Host Byte-Wide 24-Bit Mailbox Port

This block is the host-facing data port of a parallel host interface. An external 8-bit host exchanges 24-bit words with a DSP core one byte at a time. The host uses single-cycle read and write strobes and a 3-bit address. Three host addresses reach the byte lanes of a receive word and a transmit word. One more address holds an 8-bit interrupt vector. An endian control input picks which end of the address window carries the most significant byte.

On the DSP side there is a 24-bit outgoing holding register with a load strobe and an empty flag. There is also a 24-bit incoming register with a full flag and a take strobe. The block moves words between these registers and the host byte registers. Two flags manage each hand-off: receive-full and transmit-empty. Only an access to address 7 completes a word. A request output tells the host when it should service the port. While the host acknowledges a request, the block returns the interrupt vector on its data bus.

Top module: `hmbx_port`

## Requirements
- R1: After `rst` or `soft_rst`, `tx_empty`=1, `rx_full`=0, `dsp_out_empty`=1, `dsp_in_full`=0, and the vector register holds 0x0F.
- R2: `dsp_out_load` while `dsp_out_empty`=1 captures `dsp_out_word` and clears `dsp_out_empty` at that edge. A load while `dsp_out_empty`=0 is ignored.
- R3: When the outgoing register holds a word and `rx_full`=0, the next edge copies the word into the receive bytes, sets `rx_full` and sets `dsp_out_empty` again.
- R4: Receive bytes are read at addresses 5..7. With `endian_swap`=0, address 5 returns bits 23:16, address 6 returns bits 15:8 and address 7 returns bits 7:0. With `endian_swap`=1, address 7 returns bits 23:16, address 6 returns bits 15:8 and address 5 returns bits 7:0. `host_rdata` is valid in the cycle after `host_rd`.
- R5: A host read of address 7 clears `rx_full`. Reads of addresses 5 and 6 leave it set.
- R6: Host writes to addresses 5..7 fill the transmit bytes with the same endian mapping as R4. These writes take effect only while `tx_empty`=1.
- R7: A host write to address 7 clears `tx_empty`.
- R8: When `tx_empty`=0 and `dsp_in_full`=0, the next edge places the transmit bytes on `dsp_in_word` and sets both `dsp_in_full` and `tx_empty`. `dsp_in_take` clears `dsp_in_full`. `dsp_in_word` is stable while `dsp_in_full` is held.
- R9: `host_req` = (`rx_req_en` AND `rx_full`) OR (`tx_req_en` AND `tx_empty`).
- R10: Address 1 is the interrupt vector register, and the host can both read and write it.
- R11: When `host_ack` and `host_req` are both 1 at an edge, `host_rdata` shows the vector register in the next cycle. Any read strobed in that cycle has no side effect.
- R12: Addresses 0, 2, 3 and 4 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Synchronous software reset, active high |
| host_addr | input | 3 | Host register address |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| host_ack | input | 1 | Host interrupt acknowledge |
| host_req | output | 1 | Host service request |
| endian_swap | input | 1 | Byte lane order select |
| rx_req_en | input | 1 | Request on receive-full |
| tx_req_en | input | 1 | Request on transmit-empty |
| rx_full | output | 1 | Receive word waiting for host |
| tx_empty | output | 1 | Transmit bytes free for host |
| dsp_out_word | input | 24 | DSP outgoing word |
| dsp_out_load | input | 1 | DSP outgoing load strobe |
| dsp_out_empty | output | 1 | DSP outgoing register empty |
| dsp_in_word | output | 24 | Word delivered to DSP |
| dsp_in_full | output | 1 | DSP incoming register full |
| dsp_in_take | input | 1 | DSP consumes incoming word |

## Verification
The assertions check the flag hand-offs on every cycle. `rx_full` may fall only after a read of address 7 that is not overridden, and `tx_empty` may fall only after a write to address 7. A rise of `rx_full` or `dsp_in_full` must match the matching empty flag being set again. An acknowledged request must return the vector, and `dsp_in_word` must stay steady while full. The lane mapping under both endian settings can only be shown by the bench's sweeps over many words, comparing bytes with shifts of the expected word. The same holds for ignored loads and writes while a word is pending, unmapped addresses and the request equation.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 3;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int ADDR_W = 3;
    localparam int LANE_W = $clog2(LANES);

    localparam logic [ADDR_W-1:0] DATA_BASE = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(5 + LANES - 1);
    localparam logic [ADDR_W-1:0] VEC_ADDR  = ADDR_W'(1);
    localparam logic [BYTE_W-1:0] VEC_INIT  = 8'h0F;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_VEC  = 2'd1,
        SEL_DATA = 2'd2
    } sel_e;

    typedef struct packed {
        sel_e  sel;
        lane_t lane;
        logic  trig;
    } hdec_t;

    // Byte lane for a data address: lane 0 is the least significant byte.
    function automatic lane_t lane_of(input logic [ADDR_W-1:0] a, input logic swap);
        logic [ADDR_W-1:0] off;
        off = a - DATA_BASE;
        if (swap)
            return off[LANE_W-1:0];
        else
            return LANE_W'(LANES - 1) - off[LANE_W-1:0];
    endfunction
endpackage

// File: rtl/hmbx_addr_dec.sv
module hmbx_addr_dec
    import hmbx_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              swap,
    output hdec_t             dec
);
    logic in_window;

    always_comb begin
        in_window = (int'(addr) >= int'(DATA_BASE)) &&
                    (int'(addr) <  int'(DATA_BASE) + LANES);
        dec      = '0;
        dec.sel  = SEL_NONE;
        if (addr == VEC_ADDR) begin
            dec.sel = SEL_VEC;
        end else if (in_window) begin
            dec.sel  = SEL_DATA;
            dec.lane = lane_of(addr, swap);
            dec.trig = (addr == TRIG_ADDR);
        end
    end
endmodule

// File: rtl/hmbx_rx_path.sv
module hmbx_rx_path
    import hmbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t load_word,
    input  logic  rd_trig,
    input  lane_t rd_lane,
    output logic  out_empty,
    output logic  rx_full,
    output byte_t rd_byte
);
    word_t out_q;
    word_t rx_q;
    logic  out_full_q;
    logic  rx_full_q;
    logic  move;

    assign move = out_full_q & ~rx_full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q      <= '0;
            out_full_q <= 1'b0;
        end else if (load && !out_full_q) begin
            out_q      <= load_word;
            out_full_q <= 1'b1;
        end else if (move) begin
            out_full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q      <= '0;
            rx_full_q <= 1'b0;
        end else if (move) begin
            rx_q      <= out_q;
            rx_full_q <= 1'b1;
        end else if (rd_trig) begin
            rx_full_q <= 1'b0;
        end
    end

    byte_t lane_bytes [LANES];
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = rx_q[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < LANES; i++)
            if (rd_lane == LANE_W'(i)) rd_byte = lane_bytes[i];
    end

    assign out_empty = ~out_full_q;
    assign rx_full   = rx_full_q;
endmodule

// File: rtl/hmbx_tx_path.sv
module hmbx_tx_path
    import hmbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  lane_t wr_lane,
    input  byte_t wr_byte,
    input  logic  wr_trig,
    input  logic  take,
    output logic  tx_empty,
    output logic  in_full,
    output word_t in_word
);
    byte_t tx_q [LANES];
    word_t tx_word;
    word_t in_q;
    logic  tx_empty_q;
    logic  in_full_q;
    logic  xfer;

    assign xfer = ~tx_empty_q & ~in_full_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                tx_q[g] <= '0;
            else if (wr_en && tx_empty_q && wr_lane == LANE_W'(g))
                tx_q[g] <= wr_byte;
        end
        assign tx_word[g*BYTE_W +: BYTE_W] = tx_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst)
            tx_empty_q <= 1'b1;
        else if (xfer)
            tx_empty_q <= 1'b1;
        else if (wr_en && wr_trig)
            tx_empty_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q      <= '0;
            in_full_q <= 1'b0;
        end else if (xfer) begin
            in_q      <= tx_word;
            in_full_q <= 1'b1;
        end else if (take) begin
            in_full_q <= 1'b0;
        end
    end

    assign tx_empty = tx_empty_q;
    assign in_full  = in_full_q;
    assign in_word  = in_q;
endmodule

// File: rtl/hmbx_port.sv
module hmbx_port
    import hmbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              host_ack,
    output logic              host_req,
    input  logic              endian_swap,
    input  logic              rx_req_en,
    input  logic              tx_req_en,
    output logic              rx_full,
    output logic              tx_empty,
    input  logic [WORD_W-1:0] dsp_out_word,
    input  logic              dsp_out_load,
    output logic              dsp_out_empty,
    output logic [WORD_W-1:0] dsp_in_word,
    output logic              dsp_in_full,
    input  logic              dsp_in_take
);
    logic  rst_all;
    logic  ack_hit;
    logic  rd_go;
    hdec_t dec;
    byte_t rx_byte;
    byte_t vec_q;
    byte_t rdata_q;

    assign rst_all = rst | soft_rst;
    assign ack_hit = host_ack & host_req;
    assign rd_go   = host_rd & ~ack_hit;

    hmbx_addr_dec u_dec (
        .addr (host_addr),
        .swap (endian_swap),
        .dec  (dec)
    );

    hmbx_rx_path u_rx (
        .clk       (clk),
        .rst       (rst_all),
        .load      (dsp_out_load),
        .load_word (dsp_out_word),
        .rd_trig   (rd_go && dec.sel == SEL_DATA && dec.trig),
        .rd_lane   (dec.lane),
        .out_empty (dsp_out_empty),
        .rx_full   (rx_full),
        .rd_byte   (rx_byte)
    );

    hmbx_tx_path u_tx (
        .clk      (clk),
        .rst      (rst_all),
        .wr_en    (host_wr && dec.sel == SEL_DATA),
        .wr_lane  (dec.lane),
        .wr_byte  (host_wdata),
        .wr_trig  (dec.trig),
        .take     (dsp_in_take),
        .tx_empty (tx_empty),
        .in_full  (dsp_in_full),
        .in_word  (dsp_in_word)
    );

    always_ff @(posedge clk) begin
        if (rst_all)
            vec_q <= VEC_INIT;
        else if (host_wr && dec.sel == SEL_VEC)
            vec_q <= host_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst_all) begin
            rdata_q <= '0;
        end else if (ack_hit) begin
            rdata_q <= vec_q;
        end else if (rd_go) begin
            unique case (dec.sel)
                SEL_VEC:  rdata_q <= vec_q;
                SEL_DATA: rdata_q <= rx_byte;
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign host_rdata = rdata_q;
    assign host_req   = (rx_req_en & rx_full) | (tx_req_en & tx_empty);
endmodule

// File: rtl/hmbx_port_chk.sv
module hmbx_port_chk
    import hmbx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rd,
    input logic              host_wr,
    input logic [BYTE_W-1:0] host_rdata,
    input logic              host_ack,
    input logic              host_req,
    input logic              rx_req_en,
    input logic              tx_req_en,
    input logic              rx_full,
    input logic              tx_empty,
    input logic              dsp_out_empty,
    input logic [WORD_W-1:0] dsp_in_word,
    input logic              dsp_in_full,
    input logic [BYTE_W-1:0] vec_q
);
    // R3: a receive word appears only out of a held outgoing word
    assert_move_source_R3: assert property (@(posedge clk) disable iff (rst || soft_rst)
        $rose(rx_full) |-> dsp_out_empty && $past(!dsp_out_empty));

    // R3: the outgoing register empties only into the receive bytes
    assert_out_drain_R3: assert property (@(posedge clk) disable iff (rst || soft_rst)
        ($rose(dsp_out_empty) && !$past(rst || soft_rst)) |-> rx_full);

    // R5: receive-full drops only after an unmasked read of address 7
    assert_rx_clear_R5: assert property (@(posedge clk) disable iff (rst || soft_rst)
        $fell(rx_full) |-> $past(rst || soft_rst) ||
            $past(host_rd && host_addr == TRIG_ADDR && !(host_ack && host_req)));

    // R7: transmit-empty drops only after a write of address 7
    assert_tx_clear_R7: assert property (@(posedge clk) disable iff (rst || soft_rst)
        $fell(tx_empty) |-> $past(host_wr && host_addr == TRIG_ADDR));

    // R8: delivery to the DSP sets both flags together
    assert_xfer_flags_R8: assert property (@(posedge clk) disable iff (rst || soft_rst)
        $rose(dsp_in_full) |-> tx_empty && $past(!tx_empty));

    // R8: the delivered word holds while full
    assert_in_word_hold_R8: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (dsp_in_full && $past(dsp_in_full)) |-> $stable(dsp_in_word));

    // R9: no request with both enables off
    assert_req_quiet_R9: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (!rx_req_en && !tx_req_en) |-> !host_req);

    // R11: an acknowledged request returns the vector
    assert_ack_vector_R11: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (host_ack && host_req) |=> host_rdata == $past(vec_q));
endmodule

bind hmbx_port hmbx_port_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .soft_rst      (soft_rst),
    .host_addr     (host_addr),
    .host_rd       (host_rd),
    .host_wr       (host_wr),
    .host_rdata    (host_rdata),
    .host_ack      (host_ack),
    .host_req      (host_req),
    .rx_req_en     (rx_req_en),
    .tx_req_en     (tx_req_en),
    .rx_full       (rx_full),
    .tx_empty      (tx_empty),
    .dsp_out_empty (dsp_out_empty),
    .dsp_in_word   (dsp_in_word),
    .dsp_in_full   (dsp_in_full),
    .vec_q         (vec_q)
);

// File: tb/hmbx_port_bench.sv
`timescale 1ns/1ps
module hmbx_port_bench;
    logic        clk = 1'b0;
    logic        rst, soft_rst;
    logic [2:0]  host_addr;
    logic        host_rd, host_wr, host_ack;
    logic [7:0]  host_wdata, host_rdata;
    logic        host_req, endian_swap, rx_req_en, tx_req_en;
    logic        rx_full, tx_empty;
    logic [23:0] dsp_out_word, dsp_in_word;
    logic        dsp_out_load, dsp_out_empty, dsp_in_full, dsp_in_take;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hmbx_port u_hmbx_port (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic hwr(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic dload(input logic [23:0] w);
        dsp_out_word = w; dsp_out_load = 1'b1;
        tick();
        dsp_out_load = 1'b0;
    endtask

    task automatic dtake();
        dsp_in_take = 1'b1;
        tick();
        dsp_in_take = 1'b0;
    endtask

    function automatic logic [7:0] lane_byte(input logic [23:0] w, input int a, input bit e);
        int lane;
        lane = e ? (a - 5) : (7 - a);
        return 8'(w >> (lane * 8));
    endfunction

    task automatic write_word(input logic [23:0] v, input bit e);
        for (int a = 5; a <= 7; a++) hwr(3'(a), lane_byte(v, a, e));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0]  d;
        logic [23:0] w, v;
        rst = 1'b1; soft_rst = 1'b0; host_addr = '0; host_rd = 1'b0; host_wr = 1'b0;
        host_ack = 1'b0; host_wdata = '0; endian_swap = 1'b0; rx_req_en = 1'b0;
        tx_req_en = 1'b0; dsp_out_word = '0; dsp_out_load = 1'b0; dsp_in_take = 1'b0;
        repeat (3) tick();
        rst = 1'b0;

        // R1 reset state
        check("R1 tx_empty", 32'(tx_empty), 1);
        check("R1 rx_full", 32'(rx_full), 0);
        check("R1 dsp_out_empty", 32'(dsp_out_empty), 1);
        check("R1 dsp_in_full", 32'(dsp_in_full), 0);
        hrd(3'd1, d);
        check("R1 R10 vector reset", 32'(d), 32'h0F);

        // R10 vector read/write
        hwr(3'd1, 8'hA5);
        hrd(3'd1, d);
        check("R10 vector readback", 32'(d), 32'hA5);

        // R12 unmapped addresses
        for (int a = 0; a < 5; a++) begin
            if (a == 1) continue;
            hwr(3'(a), 8'hFF);
            hrd(3'(a), d);
            check("R12 unmapped read", 32'(d), 0);
        end
        hrd(3'd1, d);
        check("R12 vector untouched", 32'(d), 32'hA5);
        check("R12 tx_empty untouched", 32'(tx_empty), 1);

        // R2..R8 sweep over endian and data words
        for (int e = 0; e < 2; e++) begin
            endian_swap = 1'(e);
            for (int k = 0; k < 6; k++) begin
                w = 24'(32'h0F1E2D + k * 32'h13579B);
                dload(w);
                check("R2 out_empty cleared", 32'(dsp_out_empty), 0);
                check("R3 no early move", 32'(rx_full), 0);
                tick();
                check("R3 rx_full set", 32'(rx_full), 1);
                check("R3 out_empty set", 32'(dsp_out_empty), 1);
                for (int a = 5; a <= 7; a++) begin
                    hrd(3'(a), d);
                    check("R4 rx lane", 32'(d), 32'(lane_byte(w, a, 1'(e))));
                    check("R5 rx_full after read", 32'(rx_full), (a == 7) ? 0 : 1);
                end
                v = w ^ 24'hFFFFFF;
                hwr(3'd5, lane_byte(v, 5, 1'(e)));
                hwr(3'd6, lane_byte(v, 6, 1'(e)));
                check("R7 tx_empty before addr7", 32'(tx_empty), 1);
                hwr(3'd7, lane_byte(v, 7, 1'(e)));
                check("R7 tx_empty cleared", 32'(tx_empty), 0);
                tick();
                check("R8 dsp_in_full", 32'(dsp_in_full), 1);
                check("R8 tx_empty set", 32'(tx_empty), 1);
                check("R6 R8 dsp_in_word", 32'(dsp_in_word), 32'(v));
                dtake();
                check("R8 take clears", 32'(dsp_in_full), 0);
            end
        end

        // R2 load ignored while outgoing register is full
        endian_swap = 1'b0;
        dload(24'h111111);
        tick();
        dload(24'h222222);
        tick();
        check("R2 held while rx full", 32'(dsp_out_empty), 0);
        dload(24'h333333);
        hrd(3'd7, d);
        check("R4 first word low", 32'(d), 32'h11);
        tick();
        check("R3 second move", 32'(rx_full), 1);
        hrd(3'd5, d);
        check("R2 ignored load", 32'(d), 32'h22);
        hrd(3'd7, d);

        // R6 writes ignored while transmit word pending
        write_word(24'hABCDEF, 1'b0);
        tick();
        check("R8 first delivery", 32'(dsp_in_full), 1);
        write_word(24'h123456, 1'b0);
        tick();
        check("R8 blocked while full", 32'(tx_empty), 0);
        hwr(3'd5, 8'h00);
        check("R8 word held", 32'(dsp_in_word), 32'hABCDEF);
        dtake();
        tick();
        check("R6 ignored write", 32'(dsp_in_word), 32'h123456);
        check("R8 second delivery flags", 32'({dsp_in_full, tx_empty}), 3);
        dtake();

        // R9 request equation across flag states
        for (int s = 0; s < 2; s++) begin
            if (s == 1) begin
                dload(24'h0A0B0C);
                tick();
                write_word(24'h445566, 1'b0);
                tick();
                write_word(24'h778899, 1'b0);
            end
            for (int m = 0; m < 4; m++) begin
                rx_req_en = m[0]; tx_req_en = m[1];
                #1;
                check("R9 host_req", 32'(host_req),
                      32'((m[0] & rx_full) | (m[1] & tx_empty)));
            end
        end

        // R11 acknowledge returns vector, read side effect suppressed
        rx_req_en = 1'b1; tx_req_en = 1'b0;
        host_ack = 1'b1;
        hrd(3'd7, d);
        host_ack = 1'b0;
        check("R11 vector on ack", 32'(d), 32'hA5);
        check("R11 rx_full kept", 32'(rx_full), 1);
        rx_req_en = 1'b0;
        host_ack = 1'b1;
        hrd(3'd6, d);
        host_ack = 1'b0;
        check("R11 ack without request", 32'(d), 32'h0B);

        // R1 software reset
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        check("R1 soft flags", 32'({tx_empty, rx_full, dsp_out_empty, dsp_in_full}), 32'b1010);
        hrd(3'd1, d);
        check("R1 soft vector", 32'(d), 32'h0F);

        repeat (2) tick();
        finish_run();
    end
endmodule